// File: doc/BRIEF.md
# Receive FIFO with Trigger Level and Character Timeout

This block is the receive-side buffer of a 16550-style serial port. Bytes from the deserialiser, and null bytes standing in for detected break conditions, enter a circular queue of DEPTH entries. The host reads them out one at a time. The oldest byte is always visible on the read-data port, and a host read strobe consumes it.

A FIFO control byte, written by the host, enables the queue, selects an interrupt trigger level, and issues flush commands. A character timer counts bit-period ticks. When four character times pass with data waiting and no receive or read activity, the timer raises a timeout-pending flag. The length of a character is taken from the line control byte.

With the queue disabled, the block behaves as a single holding register.

Top module: `rx_fifo_ctl`

## Requirements
- R1: After reset the count is 0, data-ready, break, trigger, timeout and overrun flags are all 0, read data is 0x00, the queue is disabled and the trigger level is 1.
- R2: With the queue enabled (control bit 0 = 1), up to 16 bytes are held in arrival order. The read-data port shows the oldest byte, and each host read removes one byte and lowers the count by one.
- R3: Control bits 7:6 select the trigger level: 00 selects 1 byte, 01 selects 4, 10 selects 8 and 11 selects 14. The trigger flag is 1 while the queue is enabled and the count is at or above the level.
- R4: A control write with bit 1 set empties the receive queue and clears the timeout, break and overrun flags. A control write with bit 2 set raises the transmit-flush output for one cycle, starting the cycle after the write, and leaves the receive queue untouched.
- R5: A control write that changes bit 0 performs both flushes, whatever bits 1 and 2 hold.
- R6: Only control bits 7, 6, 3 and 0 are retained. A control write equal to the stored value has no effect on the queue or on the transmit-flush output.
- R7: With the queue enabled and non-empty, the timeout flag sets on the tick that completes 4 character times since the last accepted byte or host read. It never sets while the queue is empty.
- R8: The character time in ticks is 1 + (line bits 1:0 + 5) + line bit 3 + (line bit 2 ? 2 : 1). For example, 0x03 gives 10 ticks, 0x0F gives 12 and 0x00 gives 7.
- R9: A host read clears the timeout flag. A read that removes the last byte also clears the data-ready and break flags.
- R10: A break strobe stores a 0x00 byte and sets both the break and data-ready flags.
- R11: A byte arriving at a full queue is discarded and sets the overrun flag. A read of an empty queue shows 0x00 and leaves the count at 0.
- R12: With the queue disabled, one byte is held. A second byte is discarded with overrun, the trigger flag follows data-ready, and no timeout is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_push | input | 1 | Received-byte strobe |
| rx_byte | input | 8 | Received byte |
| brk_det | input | 1 | Break-detected strobe |
| host_rd | input | 1 | Host reads the data register |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write value |
| line_ctl | input | 8 | Line control byte (frame format) |
| bit_tick | input | 1 | One pulse per bit period |
| rd_data | output | 8 | Oldest byte, or 0x00 when empty |
| fifo_count | output | 5 | Bytes held |
| data_rdy | output | 1 | Data-ready flag |
| brk_flag | output | 1 | Break flag |
| trig_hit | output | 1 | Trigger level reached |
| tmo_pend | output | 1 | Character timeout pending |
| ovr_flag | output | 1 | Overrun flag |
| tx_flush | output | 1 | Transmit-queue flush pulse |

## Verification
Every flag and the count are registered. Each therefore settles on the first rising edge that samples a strobe, and read data follows on the same edge because it is taken straight from the stored queue. The transmit-flush pulse is valid for exactly the one cycle after its control write. The timeout flag rises on the same edge as the tick that completes the window, so the bench applies one tick fewer than the window, checks that the flag is still low, then applies the last tick and checks that it is high. Stimulus is driven on the falling edge and held for one cycle, and every output is sampled on a later falling edge.

// File: rtl/rx_fifo_ctl.sv
module rx_fifo_ctl #(
  parameter int DEPTH     = 16,
  parameter int DW        = 8,
  parameter int TMO_CHARS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_push,
  input  logic [DW-1:0]              rx_byte,
  input  logic                       brk_det,
  input  logic                       host_rd,
  input  logic                       fcr_wr,
  input  logic [7:0]                 fcr_wdata,
  input  logic [7:0]                 line_ctl,
  input  logic                       bit_tick,
  output logic [DW-1:0]              rd_data,
  output logic [$clog2(DEPTH):0]     fifo_count,
  output logic                       data_rdy,
  output logic                       brk_flag,
  output logic                       trig_hit,
  output logic                       tmo_pend,
  output logic                       ovr_flag,
  output logic                       tx_flush
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int TW = $clog2(TMO_CHARS * 12 + 1);
  localparam logic [7:0] KEEP = 8'hC9;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] head, tail;
  logic [CW-1:0] cnt, cnt_nx, cap, lvl;
  logic [7:0]    fcr_q;
  logic [TW-1:0] tmr, tmr_nx, lim;
  logic [3:0]    frm;

  wire en     = fcr_q[0];
  wire fcr_go = fcr_wr && (fcr_wdata != fcr_q);
  wire tog    = fcr_go && (fcr_wdata[0] ^ en);
  wire rx_fl  = fcr_go && (fcr_wdata[1] || tog);
  wire tx_fl  = fcr_go && (fcr_wdata[2] || tog);

  wire          in_push = rx_push || brk_det;
  wire [DW-1:0] in_byte = brk_det ? '0 : rx_byte;
  assign cap = en ? CW'(DEPTH) : CW'(1);
  wire full  = cnt >= cap;
  wire pop   = host_rd && (cnt != 0) && !rx_fl;
  wire acc   = in_push && !rx_fl && (!full || pop);
  wire drain = pop && (cnt == CW'(1)) && !acc;

  assign cnt_nx = rx_fl ? '0 : CW'(cnt + CW'(acc) - CW'(pop));

  assign frm = 4'd6 + {2'b0, line_ctl[1:0]} + {3'b0, line_ctl[3]} + (line_ctl[2] ? 4'd2 : 4'd1);
  assign lim = TW'(TMO_CHARS * int'(frm));

  wire restart = rx_fl || acc || pop;
  assign tmr_nx = restart ? '0 : ((bit_tick && tmr < lim) ? TW'(tmr + 1'b1) : tmr);

  always_comb begin
    case (fcr_q[7:6])
      2'b00:   lvl = CW'(1);
      2'b01:   lvl = CW'(4);
      2'b10:   lvl = CW'(8);
      default: lvl = CW'(14);
    endcase
  end

  always_ff @(posedge clk) begin
    if (acc) mem[head] <= in_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head     <= '0;
      tail     <= '0;
      cnt      <= '0;
      fcr_q    <= '0;
      tmr      <= '0;
      tmo_pend <= 1'b0;
      brk_flag <= 1'b0;
      ovr_flag <= 1'b0;
      tx_flush <= 1'b0;
    end else begin
      tx_flush <= tx_fl;
      if (fcr_go) fcr_q <= fcr_wdata & KEEP;
      cnt <= cnt_nx;
      tmr <= tmr_nx;
      if (rx_fl) begin
        head <= '0;
        tail <= '0;
      end else begin
        if (acc) head <= (head == AW'(DEPTH - 1)) ? '0 : head + 1'b1;
        if (pop) tail <= (tail == AW'(DEPTH - 1)) ? '0 : tail + 1'b1;
      end
      if (rx_fl)                ovr_flag <= 1'b0;
      else if (in_push && !acc) ovr_flag <= 1'b1;
      if (rx_fl)        brk_flag <= 1'b0;
      else if (brk_det) brk_flag <= 1'b1;
      else if (drain)   brk_flag <= 1'b0;
      if (rx_fl || host_rd)                          tmo_pend <= 1'b0;
      else if (en && tmr_nx >= lim && cnt_nx != '0)  tmo_pend <= 1'b1;
    end
  end

  assign rd_data    = (cnt != '0) ? mem[tail] : '0;
  assign fifo_count = cnt;
  assign data_rdy   = cnt != '0;
  assign trig_hit   = en ? (cnt >= lvl) : (cnt != '0);

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && fcr_wdata[1] && fcr_wdata != fcr_q) |=> (fifo_count == '0 && !tmo_pend && !brk_flag)); // R4
  AST_TOGGLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && (fcr_wdata[0] != fcr_q[0])) |=> (fifo_count == '0 && tx_flush)); // R5
  AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pend |-> data_rdy); // R7
  AST_READ_CLEARS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> !tmo_pend); // R9
  AST_BREAK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_det && !fcr_wr) |=> (brk_flag && data_rdy)); // R10
  AST_FULL_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && en && fifo_count == CW'(DEPTH) && !host_rd && !fcr_wr) |=> (ovr_flag && fifo_count == CW'(DEPTH))); // R11
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && fifo_count == '0 && !rx_push && !brk_det && !fcr_wr) |=> (fifo_count == '0)); // R11
endmodule

// File: tb/rx_fifo_ctl_tb_top.sv
`timescale 1ns/1ps
module rx_fifo_ctl_tb_top;
  logic clk = 0, rst_n = 0;
  logic rx_push = 0, brk_det = 0, host_rd = 0, fcr_wr = 0, bit_tick = 0;
  logic [7:0] rx_byte = 0, fcr_wdata = 0, line_ctl = 8'h03;
  logic [7:0] rd_data;
  logic [4:0] fifo_count;
  logic data_rdy, brk_flag, trig_hit, tmo_pend, ovr_flag, tx_flush;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_fifo_ctl dut_i (.clk, .rst_n, .rx_push, .rx_byte, .brk_det, .host_rd, .fcr_wr,
    .fcr_wdata, .line_ctl, .bit_tick, .rd_data, .fifo_count, .data_rdy, .brk_flag,
    .trig_hit, .tmo_pend, .ovr_flag, .tx_flush);

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk) rx_push = 1; rx_byte = b;
    @(negedge clk) rx_push = 0;
  endtask
  task automatic brk();
    @(negedge clk) brk_det = 1;
    @(negedge clk) brk_det = 0;
  endtask
  task automatic rd(output logic [7:0] b);
    @(negedge clk) b = rd_data; host_rd = 1;
    @(negedge clk) host_rd = 0;
  endtask
  task automatic wfcr(input logic [7:0] v);
    @(negedge clk) fcr_wr = 1; fcr_wdata = v;
    @(negedge clk) fcr_wr = 0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_tick = 1;
      @(negedge clk) bit_tick = 0;
    end
  endtask

  task automatic t_reset();
    chk("R1 count", fifo_count, 0); chk("R1 dr", data_rdy, 0);
    chk("R1 brk", brk_flag, 0); chk("R1 tmo", tmo_pend, 0);
    chk("R1 ovr", ovr_flag, 0); chk("R1 data", rd_data, 0); chk("R1 trig", trig_hit, 0);
  endtask

  task automatic t_order();
    logic [7:0] b;
    wfcr(8'h01);
    chk("R5 enable toggle tx_flush", tx_flush, 1);
    for (int i = 0; i < 16; i++) push(8'h10 + 8'(i));
    chk("R2 full count", fifo_count, 16);
    push(8'hEE);
    chk("R11 overrun", ovr_flag, 1); chk("R11 count held", fifo_count, 16);
    for (int i = 0; i < 16; i++) begin
      rd(b); chk("R2 order", b, 8'h10 + i);
    end
    chk("R2 empty", fifo_count, 0); chk("R2 dr low", data_rdy, 0);
    rd(b);
    chk("R11 empty read data", b, 0); chk("R11 empty read count", fifo_count, 0);
  endtask

  task automatic t_trigger();
    int lv[4] = '{1, 4, 8, 14};
    for (int s = 0; s < 4; s++) begin
      wfcr({2'(s), 6'b000001});
      for (int i = 0; i < lv[s] - 1; i++) push(8'(i));
      chk("R3 below level", trig_hit, 0);
      push(8'hAA);
      chk("R3 at level", trig_hit, 1);
      wfcr({2'(s), 6'b000011});
      chk("R4 rx flush", fifo_count, 0); chk("R4 ovr cleared", ovr_flag, 0);
    end
  endtask

  task automatic t_flush_equal();
    push(8'h01); push(8'h02);
    wfcr(8'h05);
    chk("R4 tx flush pulse", tx_flush, 1);
    chk("R4 rx kept", fifo_count, 2);
    @(negedge clk);
    chk("R4 pulse one cycle", tx_flush, 0);
    wfcr(8'h01);
    chk("R6 equal write count", fifo_count, 2); chk("R6 equal write no pulse", tx_flush, 0);
    wfcr(8'h31);
    chk("R6 unretained bits", fifo_count, 2);
    chk("R6 level 1 kept", trig_hit, 1);
    wfcr(8'h00);
    chk("R5 disable flush", fifo_count, 0); chk("R5 disable tx", tx_flush, 1);
  endtask

  task automatic t_disabled();
    logic [7:0] b;
    push(8'hA5);
    chk("R12 one held", fifo_count, 1); chk("R12 trig", trig_hit, 1);
    push(8'h5A);
    chk("R12 overrun", ovr_flag, 1); chk("R12 keeps first", rd_data, 8'hA5);
    ticks(200);
    chk("R12 no timeout", tmo_pend, 0);
    rd(b);
    chk("R12 read", b, 8'hA5); chk("R12 empty", data_rdy, 0);
    wfcr(8'h01);
    chk("R5 enable clears ovr", ovr_flag, 0);
  endtask

  task automatic t_timeout(input logic [7:0] lc, input int win);
    logic [7:0] b;
    line_ctl = lc;
    push(8'h31); push(8'h32);
    ticks(win - 1);
    chk("R8 before window", tmo_pend, 0);
    ticks(1);
    chk("R7 R8 at window", tmo_pend, 1);
    rd(b);
    chk("R9 read clears tmo", tmo_pend, 0);
    ticks(win - 1);
    chk("R7 restart by read", tmo_pend, 0);
    ticks(1);
    chk("R7 again", tmo_pend, 1);
    rd(b);
    ticks(win + 5);
    chk("R7 empty no tmo", tmo_pend, 0);
  endtask

  task automatic t_break();
    logic [7:0] b;
    push(8'h55); brk();
    chk("R10 count", fifo_count, 2); chk("R10 brk", brk_flag, 1); chk("R10 dr", data_rdy, 1);
    rd(b);
    chk("R9 brk kept", brk_flag, 1);
    rd(b);
    chk("R10 null byte", b, 0); chk("R9 brk cleared", brk_flag, 0); chk("R9 dr cleared", data_rdy, 0);
    brk();
    wfcr(8'h03);
    chk("R4 flush clears brk", brk_flag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_trigger();
    t_flush_equal();
    t_disabled();
    t_timeout(8'h03, 40);
    t_timeout(8'h0F, 48);
    t_timeout(8'h00, 28);
    t_break();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule